// File: doc/BRIEF.md
# Thermal and Supply Fault Supervisor

This block gathers the device-wide protection conditions of a three-leg power driver and decides when the legs must be forced to high impedance. Its inputs are digital flags: a temperature warning, a temperature shutdown, one undervoltage flag per monitored supply, one latched overcurrent flag per leg, and the three active-low leg resets. Its outputs are an active-low warning, an active-low fault and a single Hi-Z request shared by every leg.

Undervoltage recovers by itself once every supply is good again. An over-temperature shutdown is held in a latch. That latch can only be cleared when all three leg resets are low together while the shutdown flag is inactive. Every input is first passed through a two-flop synchronizer and then a glitch filter. The filter only accepts a new level after it has been seen on consecutive samples. After reset the supplies are assumed to be low, so the legs stay disabled until the supply flags have read as good for a full filter window.

Top module: `prot_supervisor`

## Requirements
- R1: While the filtered warning flag is high, `warn_n_o` is 0. The warning by itself leaves `fault_n_o` at 1 and `hiz_all_o` at 0.
- R2: While the filtered shutdown flag is high, `hiz_all_o` is 1 and `fault_n_o` is 0.
- R3: The shutdown is latched. It stays in force after the shutdown flag clears. Pulling only some of the three leg resets low (active low, bit i = leg i) does not clear it.
- R4: Once all three leg resets are seen low with the shutdown flag inactive, the latch releases and `fault_n_o` returns to 1. `hiz_all_o` stays at 1 until all three resets are high again.
- R5: An undervoltage flag on any supply sets `hiz_all_o` to 1 and `fault_n_o` to 0.
- R6: When every undervoltage flag is clear and no shutdown is pending or latched, `hiz_all_o` returns to 0 without any reset action.
- R7: A latched overcurrent flag on any leg sets `fault_n_o` to 0. It does not by itself set `hiz_all_o`.
- R8: Reset state: `warn_n_o`=1, `fault_n_o`=0, `hiz_all_o`=1. Operation stays withheld until the supply flags have been filtered as good.
- R9: A change in an input that lasts fewer than FILT_LEN (4) consecutive samples has no effect on any output.
- R10: All three leg resets held low do not release the latch while the shutdown flag is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ot_warn_i | input | 1 | Temperature warning flag |
| ot_shut_i | input | 1 | Temperature shutdown flag |
| uv_i | input | N_SUPPLY | Undervoltage flag per supply |
| oc_lat_i | input | N_LEGS | Latched overcurrent flag per leg |
| leg_rst_n_i | input | N_LEGS | Active-low reset per leg |
| warn_n_o | output | 1 | Active-low warning, registered |
| fault_n_o | output | 1 | Active-low fault, registered |
| hiz_all_o | output | 1 | Hi-Z request to all legs, registered |

## Verification
On every cycle the assertions relate the filtered flags and the latch state to the registered outputs one clock later. They also check that the latch never leaves its tripped state unless all resets are low and the shutdown flag is clear. The behaviour that depends on input history can only be shown by the bench scenarios: that short glitches are rejected, that a partial reset fails to clear the latch, the power-up withholding, and the order of release followed by resume.

// File: rtl/prot_sup_pkg.sv
package prot_sup_pkg;
  typedef enum logic [1:0] {
    OT_IDLE    = 2'd0,
    OT_TRIPPED = 2'd1,
    OT_RELEASE = 2'd2
  } ot_state_e;
endpackage

// File: rtl/flag_sync_filter.sv
// Per-bit synchronizer followed by a persistence filter.
module flag_sync_filter #(
  parameter int           WIDTH       = 4,
  parameter int           SYNC_STAGES = 2,
  parameter int           FILT_LEN    = 4,
  parameter logic [WIDTH-1:0] INIT    = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [SYNC_STAGES-1:0] chain;
    logic [CW-1:0]          cnt;
    logic                   q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= {SYNC_STAGES{INIT[i]}};
        cnt   <= '0;
        q     <= INIT[i];
      end else begin
        chain <= {chain[SYNC_STAGES-2:0], din[i]};
        if (chain[SYNC_STAGES-1] != q) begin
          if (cnt == CNT_LAST) begin
            q   <= chain[SYNC_STAGES-1];
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end

    assign dout[i] = q;
  end
endmodule

// File: rtl/ot_latch.sv
// Over-temperature shutdown latch with all-legs reset release protocol.
module ot_latch
  import prot_sup_pkg::*;
#(
  parameter int N_LEGS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shut_f,
  input  logic [N_LEGS-1:0] leg_rst_n_f,
  output ot_state_e         state
);
  ot_state_e nxt;
  logic      all_low;
  logic      all_high;

  assign all_low  = ~|leg_rst_n_f;
  assign all_high = &leg_rst_n_f;

  always_comb begin
    nxt = state;
    unique case (state)
      OT_IDLE:    if (shut_f) nxt = OT_TRIPPED;
      OT_TRIPPED: if (!shut_f && all_low) nxt = OT_RELEASE;
      OT_RELEASE: begin
        if (shut_f)        nxt = OT_TRIPPED;
        else if (all_high) nxt = OT_IDLE;
      end
      default:    nxt = OT_TRIPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= OT_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor
  import prot_sup_pkg::*;
#(
  parameter int N_LEGS      = 3,
  parameter int N_SUPPLY    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ot_warn_i,
  input  logic                ot_shut_i,
  input  logic [N_SUPPLY-1:0] uv_i,
  input  logic [N_LEGS-1:0]   oc_lat_i,
  input  logic [N_LEGS-1:0]   leg_rst_n_i,
  output logic                warn_n_o,
  output logic                fault_n_o,
  output logic                hiz_all_o
);
  localparam int W = 2 + N_SUPPLY + 2 * N_LEGS;
  // Supplies assumed bad and leg resets released at power-up.
  localparam logic [W-1:0] INIT = {{N_LEGS{1'b1}}, {N_LEGS{1'b0}}, {N_SUPPLY{1'b1}}, 2'b00};

  logic [W-1:0]        raw, filt;
  logic                warn_f, shut_f, uv_any, oc_any;
  logic [N_LEGS-1:0]   leg_rst_n_f;
  logic                legs_all_low, legs_all_high;
  ot_state_e           ot_state;

  assign raw = {leg_rst_n_i, oc_lat_i, uv_i, ot_shut_i, ot_warn_i};

  flag_sync_filter #(
    .WIDTH(W), .SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN), .INIT(INIT)
  ) u_filt (
    .clk(clk), .rst(rst), .din(raw), .dout(filt)
  );

  assign warn_f        = filt[0];
  assign shut_f        = filt[1];
  assign uv_any        = |filt[2 +: N_SUPPLY];
  assign oc_any        = |filt[2 + N_SUPPLY +: N_LEGS];
  assign leg_rst_n_f   = filt[2 + N_SUPPLY + N_LEGS +: N_LEGS];
  assign legs_all_low  = ~|leg_rst_n_f;
  assign legs_all_high = &leg_rst_n_f;

  ot_latch #(.N_LEGS(N_LEGS)) u_ot (
    .clk(clk), .rst(rst), .shut_f(shut_f), .leg_rst_n_f(leg_rst_n_f), .state(ot_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_n_o  <= 1'b1;
      fault_n_o <= 1'b0;
      hiz_all_o <= 1'b1;
    end else begin
      warn_n_o  <= !warn_f;
      fault_n_o <= !(shut_f || (ot_state == OT_TRIPPED) || uv_any || oc_any);
      hiz_all_o <= shut_f || (ot_state != OT_IDLE) || uv_any;
    end
  end
endmodule

// File: rtl/prot_supervisor_chk.sv
module prot_supervisor_chk
  import prot_sup_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      warn_f,
  input logic      shut_f,
  input logic      uv_any,
  input logic      oc_any,
  input logic      legs_all_low,
  input logic      legs_all_high,
  input ot_state_e ot_state,
  input logic      warn_n_o,
  input logic      fault_n_o,
  input logic      hiz_all_o
);
  a_r1_warn_low: assert property (@(posedge clk) disable iff (rst)
    warn_f |=> !warn_n_o);
  a_r1_warn_high: assert property (@(posedge clk) disable iff (rst)
    !warn_f |=> warn_n_o);
  a_r2_shut_hiz: assert property (@(posedge clk) disable iff (rst)
    shut_f |=> (hiz_all_o && !fault_n_o));
  a_r3_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (ot_state == OT_TRIPPED && !(legs_all_low && !shut_f)) |=> ot_state == OT_TRIPPED);
  a_r4_release_hiz: assert property (@(posedge clk) disable iff (rst)
    (ot_state == OT_RELEASE && !legs_all_high && !shut_f) |=> (ot_state == OT_RELEASE && hiz_all_o));
  a_r5_uv_hiz: assert property (@(posedge clk) disable iff (rst)
    uv_any |=> (hiz_all_o && !fault_n_o));
  a_r6_auto_resume: assert property (@(posedge clk) disable iff (rst)
    (!uv_any && !shut_f && ot_state == OT_IDLE) |=> !hiz_all_o);
  a_r7_oc_fault: assert property (@(posedge clk) disable iff (rst)
    oc_any |=> !fault_n_o);
  a_r10_no_release_hot: assert property (@(posedge clk) disable iff (rst)
    (ot_state == OT_TRIPPED && shut_f) |=> ot_state == OT_TRIPPED);
endmodule

bind prot_supervisor prot_supervisor_chk u_chk (
  .clk(clk), .rst(rst), .warn_f(warn_f), .shut_f(shut_f), .uv_any(uv_any),
  .oc_any(oc_any), .legs_all_low(legs_all_low), .legs_all_high(legs_all_high),
  .ot_state(ot_state), .warn_n_o(warn_n_o), .fault_n_o(fault_n_o), .hiz_all_o(hiz_all_o)
);

// File: tb/sim_prot_supervisor.sv
module sim_prot_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ot_warn_i = 1'b0;
  logic       ot_shut_i = 1'b0;
  logic [1:0] uv_i = 2'b00;
  logic [2:0] oc_lat_i = 3'b000;
  logic [2:0] leg_rst_n_i = 3'b111;
  logic       warn_n_o, fault_n_o, hiz_all_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_supervisor u0 (
    .clk(clk), .rst(rst), .ot_warn_i(ot_warn_i), .ot_shut_i(ot_shut_i),
    .uv_i(uv_i), .oc_lat_i(oc_lat_i), .leg_rst_n_i(leg_rst_n_i),
    .warn_n_o(warn_n_o), .fault_n_o(fault_n_o), .hiz_all_o(hiz_all_o)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect3(input string req, input logic w, input logic f, input logic h);
    checks++;
    if ({warn_n_o, fault_n_o, hiz_all_o} !== {w, f, h}) begin
      fails++;
      $display("FAIL %s: warn_n/fault_n/hiz actual %b%b%b expected %b%b%b",
               req, warn_n_o, fault_n_o, hiz_all_o, w, f, h);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    wait_cyc(3);
    expect3("R8 in reset", 1'b1, 1'b0, 1'b1);
    rst = 1'b0;
    wait_cyc(1);
    expect3("R8 withheld after reset", 1'b1, 1'b0, 1'b1);
    wait_cyc(SETTLE);
    expect3("R6 resume after power-up", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_warn;
    ot_warn_i = 1'b1;
    wait_cyc(SETTLE);
    expect3("R1 warning active", 1'b0, 1'b1, 1'b0);
    ot_warn_i = 1'b0;
    wait_cyc(SETTLE);
    expect3("R1 warning cleared", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_glitch;
    ot_warn_i = 1'b1;
    uv_i      = 2'b01;
    wait_cyc(3);
    ot_warn_i = 1'b0;
    uv_i      = 2'b00;
    for (int k = 0; k < 12; k++) begin
      wait_cyc(1);
      expect3("R9 short glitch ignored", 1'b1, 1'b1, 1'b0);
    end
  endtask

  task automatic t_ot;
    ot_shut_i = 1'b1;
    wait_cyc(SETTLE);
    expect3("R2 shutdown active", 1'b1, 1'b0, 1'b1);
    ot_shut_i = 1'b0;
    wait_cyc(SETTLE);
    expect3("R3 latched after flag clears", 1'b1, 1'b0, 1'b1);
    leg_rst_n_i = 3'b100;
    wait_cyc(SETTLE);
    expect3("R3 partial reset no release", 1'b1, 1'b0, 1'b1);
    leg_rst_n_i = 3'b111;
    wait_cyc(SETTLE);
    expect3("R3 still latched", 1'b1, 1'b0, 1'b1);
    ot_shut_i = 1'b1;
    wait_cyc(SETTLE);
    leg_rst_n_i = 3'b000;
    wait_cyc(SETTLE);
    expect3("R10 no release while hot", 1'b1, 1'b0, 1'b1);
    ot_shut_i = 1'b0;
    wait_cyc(SETTLE);
    expect3("R4 released, resets low", 1'b1, 1'b1, 1'b1);
    leg_rst_n_i = 3'b111;
    wait_cyc(SETTLE);
    expect3("R4 resume after resets high", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_uv;
    uv_i = 2'b10;
    wait_cyc(SETTLE);
    expect3("R5 undervoltage supply 1", 1'b1, 1'b0, 1'b1);
    uv_i = 2'b00;
    wait_cyc(SETTLE);
    expect3("R6 auto recovery", 1'b1, 1'b1, 1'b0);
    uv_i = 2'b01;
    wait_cyc(SETTLE);
    expect3("R5 undervoltage supply 0", 1'b1, 1'b0, 1'b1);
    uv_i = 2'b00;
    wait_cyc(SETTLE);
    expect3("R6 auto recovery again", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_oc;
    oc_lat_i = 3'b100;
    wait_cyc(SETTLE);
    expect3("R7 overcurrent leg 2", 1'b1, 1'b0, 1'b0);
    oc_lat_i = 3'b000;
    wait_cyc(SETTLE);
    expect3("R7 overcurrent cleared", 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    wait_cyc(1);
    t_reset();
    t_warn();
    t_glitch();
    t_ot();
    t_uv();
    t_oc();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule